// File: doc/BRIEF.md
# Alarm Status and Interrupt Register

This block keeps the software-visible status of one receive alarm for a single framer channel. The receive framing logic drives an alarm-present level into the block. The block brings that level into its own clock domain. It exposes the live level as a read-only state bit. It also records every transition of the level, rising or falling, in a sticky change bit.

The change bit drives a level interrupt through a mask bit. Software picks how the change bit is cleared through a mode bit. In clear-on-read mode, a read of the status register clears it. In write-to-clear mode, it stays set until software writes a 1 to it. A write of 1 to the change bit clears it in either mode. Access is through a plain synchronous port with an address, write data, a read strobe and a write strobe. Read data appears one cycle after the read strobe.

Top module: `alm_status_irq`

## Requirements
- R1: Bit 7 of the status register (offset 0x02) reads as the alarm-present input after two synchronizing flops. It is 1 while the alarm is present and 0 when it is absent, and writes do not change it.
- R2: Bit 2 of the status register (the change bit) is set when the synchronized alarm level changes, on both rising and falling transitions.
- R3: In write-to-clear mode (control bit 0 at offset 0x00 equal to 0), reads of the status register leave the change bit set.
- R4: In clear-on-read mode (control bit 0 equal to 1), a status read returns the change bit as it was and then clears it. Reads of other offsets do not clear it.
- R5: A write to the status register with bit 2 equal to 1 clears the change bit. With bit 2 equal to 0, the write has no effect.
- R6: The `irq` output equals the change bit ANDed with the interrupt enable, which is bit 1 at offset 0x01. Both are taken after the same clock edge.
- R7: The clear-mode bit (offset 0x00, bit 0) and the enable bit (offset 0x01, bit 1) can be written and read back. All other bits of those registers read as 0.
- R8: When a transition of the alarm coincides with a clearing read or write, the change bit ends up set.
- R9: After reset, every register bit is 0, `irq` is 0, and write-to-clear mode is selected.
- R10: `rd_data` is registered and shows the addressed register one cycle after `rd_en`. It is 0 in any cycle that follows no read, and after a read of an unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alarm_in | input | 1 | Alarm-present level from receive framing logic (asynchronous) |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | ADDR_W | Register offset |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt, change bit masked by enable |

## Verification
The alarm input is driven through both rising and falling transitions. Each transition is followed by status reads, under each clear mode and with the mask both open and closed. A read that clears the change bit can therefore be told apart from one that leaves it set, and a masked interrupt from an absent one. Writes to the status register are sent with bit 2 at 0 and at 1, and with the read-only bit 7 set. This separates a true write-one-to-clear from a write that stores data. The last patterns place the alarm transition on exactly the same edge as a clearing read or write, which shows whether the set has priority.

// File: rtl/alm_pkg.sv
package alm_pkg;
  // Field positions inside the 8-bit registers
  localparam int STATE_BIT = 7;
  localparam int CHG_BIT   = 2;
  localparam int IEN_BIT   = 1;
  localparam int MODE_BIT  = 0;

  // Register offsets
  localparam int OFS_CTRL = 0;
  localparam int OFS_IEN  = 1;
  localparam int OFS_STAT = 2;

  typedef enum logic {
    CLR_BY_WRITE = 1'b0,
    CLR_BY_READ  = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/alm_sync.sv
module alm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/alm_change_det.sv
module alm_change_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic prev_q,
  output logic change
);
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign change = lvl ^ prev_q;
endmodule

// File: rtl/alm_sticky.sv
module alm_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag_q,
  output logic flag_next
);
  // a new event outranks any clear in the same cycle
  assign flag_next = set | (flag_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_next;
  end
endmodule

// File: rtl/alm_regs.sv
module alm_regs
  import alm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              alarm_lvl,
  input  logic              chg_q,
  input  logic              chg_next,
  output clr_mode_e         mode_q,
  output logic              ien_q,
  output logic              chg_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic              hit_ctrl, hit_ien, hit_stat;
  logic              ien_next;
  logic [DATA_W-1:0] rd_mux;

  assign hit_ctrl = (addr == A_CTRL);
  assign hit_ien  = (addr == A_IEN);
  assign hit_stat = (addr == A_STAT);

  assign chg_clr = (rd_en & hit_stat & (mode_q == CLR_BY_READ))
                 | (wr_en & hit_stat & wr_data[CHG_BIT]);

  assign ien_next = (wr_en & hit_ien) ? wr_data[IEN_BIT] : ien_q;

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) rd_mux[MODE_BIT] = mode_q;
    if (hit_ien)  rd_mux[IEN_BIT]  = ien_q;
    if (hit_stat) begin
      rd_mux[STATE_BIT] = alarm_lvl;
      rd_mux[CHG_BIT]   = chg_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= CLR_BY_WRITE;
      ien_q   <= 1'b0;
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      if (wr_en && hit_ctrl) mode_q <= clr_mode_e'(wr_data[MODE_BIT]);
      ien_q   <= ien_next;
      rd_data <= rd_en ? rd_mux : '0;
      irq     <= chg_next & ien_next;
    end
  end
endmodule

// File: rtl/alm_status_irq.sv
module alm_status_irq
  import alm_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alarm_in,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic      alarm_lvl;
  logic      alarm_prev;
  logic      alarm_chg;
  logic      chg_q;
  logic      chg_next;
  logic      chg_clr;
  clr_mode_e mode_q;
  logic      ien_q;

  alm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (alarm_in),
    .q   (alarm_lvl)
  );

  alm_change_det u_det (
    .clk    (clk),
    .rst    (rst),
    .lvl    (alarm_lvl),
    .prev_q (alarm_prev),
    .change (alarm_chg)
  );

  alm_sticky u_chg (
    .clk       (clk),
    .rst       (rst),
    .set       (alarm_chg),
    .clr       (chg_clr),
    .flag_q    (chg_q),
    .flag_next (chg_next)
  );

  alm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .alarm_lvl (alarm_lvl),
    .chg_q     (chg_q),
    .chg_next  (chg_next),
    .mode_q    (mode_q),
    .ien_q     (ien_q),
    .chg_clr   (chg_clr),
    .rd_data   (rd_data),
    .irq       (irq)
  );
endmodule

// File: rtl/alm_status_irq_chk.sv
module alm_status_irq_chk
  import alm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq,
  input logic              alarm_lvl,
  input logic              alarm_prev,
  input logic              chg_q,
  input logic              mode_q,
  input logic              ien_q
);
  logic stat_hit;
  assign stat_hit = (addr == ADDR_W'(OFS_STAT));

  // R1
  r1_state_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && stat_hit) |=> (rd_data[STATE_BIT] == $past(alarm_lvl)));

  // R2
  r2_change_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (alarm_lvl != alarm_prev) |=> chg_q);

  // R3
  r3_read_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_q && !mode_q && !(wr_en && stat_hit && wr_data[CHG_BIT])) |=> chg_q);

  // R4
  r4_read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && stat_hit && mode_q && (alarm_lvl == alarm_prev)) |=> !chg_q);

  // R6
  r6_irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (chg_q && ien_q));

  // R8
  r8_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((alarm_lvl != alarm_prev) && (rd_en || wr_en) && stat_hit) |=> chg_q);

  // R10
  r10_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));
endmodule

bind alm_status_irq alm_status_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .addr       (addr),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .irq        (irq),
  .alarm_lvl  (alarm_lvl),
  .alarm_prev (alarm_prev),
  .chg_q      (chg_q),
  .mode_q     (mode_q),
  .ien_q      (ien_q)
);

// File: tb/alm_status_irq_tb.sv
module alm_status_irq_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int NV     = 20;

  // vector: alarm(1) op(2: 0 none,1 write,2 read) addr(8) wdata(8) exp_rd(8) exp_irq(1)
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 2'd2, 8'h02, 8'h00, 8'h00, 1'b0}, // R9 status idle
    {1'b0, 2'd1, 8'h01, 8'h02, 8'h00, 1'b0}, // R7 enable on
    {1'b1, 2'd2, 8'h01, 8'h00, 8'h02, 1'b1}, // R2 rise, R7 readback
    {1'b1, 2'd2, 8'h02, 8'h00, 8'h84, 1'b1}, // R1 R3 read keeps
    {1'b1, 2'd2, 8'h02, 8'h00, 8'h84, 1'b1}, // R3 still set
    {1'b1, 2'd1, 8'h02, 8'h80, 8'h00, 1'b1}, // R5 bit2=0 no effect
    {1'b1, 2'd1, 8'h02, 8'h04, 8'h00, 1'b0}, // R5 w1c
    {1'b1, 2'd2, 8'h02, 8'h00, 8'h80, 1'b0}, // R1 R5 bit7 kept
    {1'b0, 2'd2, 8'h02, 8'h00, 8'h04, 1'b1}, // R2 fall
    {1'b0, 2'd1, 8'h00, 8'hFF, 8'h00, 1'b1}, // R7 clear-on-read mode
    {1'b0, 2'd2, 8'h00, 8'h00, 8'h01, 1'b1}, // R4 R7 other-offset read keeps
    {1'b0, 2'd2, 8'h02, 8'h00, 8'h04, 1'b0}, // R4 read returns then clears
    {1'b0, 2'd2, 8'h02, 8'h00, 8'h00, 1'b0}, // R4 cleared
    {1'b1, 2'd1, 8'h01, 8'h00, 8'h00, 1'b0}, // R6 masked
    {1'b1, 2'd2, 8'h02, 8'h00, 8'h84, 1'b0}, // R4 R6
    {1'b1, 2'd1, 8'h01, 8'hFF, 8'h00, 1'b0}, // R6 unmask, flag clear
    {1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 1'b1}, // R2 R6
    {1'b0, 2'd1, 8'h00, 8'h00, 8'h00, 1'b1}, // R7 back to w1c
    {1'b0, 2'd2, 8'h02, 8'h00, 8'h04, 1'b1}, // R3
    {1'b0, 2'd1, 8'h02, 8'h04, 8'h00, 1'b0}  // R5
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              alarm_in = 1'b0;
  logic              rd_en = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alm_status_irq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .alarm_in(alarm_in),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq     (irq)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; addr = '0;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; addr = '0; wr_data = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 irq", {7'd0, irq}, 8'h00);
    do_read(8'h00); check("R9 ctrl", rd_data, 8'h00);
    do_read(8'h01); check("R9 ien", rd_data, 8'h00);
    do_read(8'h02); check("R9 stat", rd_data, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      @(negedge clk); alarm_in = v[27];
      repeat (4) @(negedge clk);
      case (v[26:25])
        2'd1: do_write(v[24:17], v[16:9]);
        2'd2: begin
          do_read(v[24:17]);
          check($sformatf("R10 vec%0d rd_data", i), rd_data, v[8:1]);
        end
        default: @(negedge clk);
      endcase
      check($sformatf("R6 vec%0d irq", i), {7'd0, irq}, {7'd0, v[0]});
    end

    // R8 read-clear on the same edge as a rise, clear-on-read mode
    do_write(8'h00, 8'h01);
    @(negedge clk); alarm_in = 1'b1;
    @(negedge clk);
    @(negedge clk); rd_en = 1'b1; addr = 8'h02;
    @(negedge clk); rd_en = 1'b0; addr = '0;
    check("R8 read data at collision", rd_data, 8'h80);
    check("R8 irq kept after read", {7'd0, irq}, 8'h01);
    do_read(8'h02); check("R8 flag survived", rd_data, 8'h84);
    check("R4 cleared after read", {7'd0, irq}, 8'h00);

    // R8 write-clear on the same edge as a fall, write-to-clear mode
    do_write(8'h00, 8'h00);
    @(negedge clk); alarm_in = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 8'h02; wr_data = 8'h04;
    @(negedge clk); wr_en = 1'b0; addr = '0; wr_data = '0;
    check("R8 irq kept after write", {7'd0, irq}, 8'h01);
    do_write(8'h02, 8'h04);
    check("R5 cleared", {7'd0, irq}, 8'h00);

    // R10 unmapped offset and idle cycle
    do_read(8'h03); check("R10 unmapped", rd_data, 8'h00);
    @(negedge clk); check("R10 idle", rd_data, 8'h00);

    // R9 reset mid-run
    do_write(8'h00, 8'h01);
    @(negedge clk); alarm_in = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 pre-reset irq", {7'd0, irq}, 8'h01);
    alarm_in = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 irq after reset", {7'd0, irq}, 8'h00);
    do_read(8'h00); check("R9 mode after reset", rd_data, 8'h00);
    do_read(8'h01); check("R9 ien after reset", rd_data, 8'h00);
    do_read(8'h02); check("R9 stat after reset", rd_data, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule